// File: doc/BRIEF.md
# Register Window Decoder for a Byte-Wide SRAM Space

This block stands between a host bus and an external byte-wide SRAM that fills a 512K-byte address space. It watches the 19-bit address together with active-low chip-enable, output-enable and write-enable strobes. For most of the space it forwards the strobes to the SRAM. The 16 highest locations are different: there the SRAM chip-enable and output-enable stay inactive, and a small internal register file answers the access instead. This leaves 524,272 bytes of SRAM usable below the window.

A power-good input is synchronized and gates every access. While power is reported bad, no register is written and no SRAM strobe or data drive is issued. The decision is made at the start of each access. If power-good drops while an access is in progress, the rest of that access stays blocked until chip-enable is released, even if power returns in the meantime. Register offset 0 is a flags register. Its bit 4 reflects a battery-low status input, which is synchronized, and that bit cannot be written.

The host strobes are sampled on the clock. Every output is registered, so it follows the inputs by one clock cycle.

Top module: `regwin_decoder`

## Requirements
- R1: The register window is every address whose bits 18..4 are all ones (7FFF0h to 7FFFFh). Address bits 3..0 select one of 16 byte registers. Address 7FFEFh and every lower address belong to the SRAM.
- R2: An access with chip-enable low and an address inside the window holds `sram_ce_n` and `sram_oe_n` high in the following cycle.
- R3: With power good and an address outside the window, the cycle after the inputs are sampled gives `sram_ce_n` = `ce_n`, `sram_oe_n` = `ce_n` OR `oe_n` and `sram_we_n` = `ce_n` OR `we_n`, and `dq_oe` stays low.
- R4: With chip-enable and write-enable both low and the address in the window, `wdata` is stored in the selected register. With chip-enable and output-enable low, write-enable high and the address in the window, the next cycle gives `dq_oe` = 1 and `dq_out` = that register's value.
- R5: `dq_oe` is low in any cycle that follows a sample with write-enable low. This also holds when write-enable falls while output-enable is already low. `dq_oe` and an active `sram_oe_n` never occur together.
- R6: While chip-enable is high, the next cycle has `dq_oe` = 0, `dq_out` = 0 and all three SRAM strobes high.
- R7: While the synchronized power-good is low, all SRAM strobes stay high, `dq_oe` stays low and register writes are ignored. Power-good and battery-low each pass through a two-flop synchronizer.
- R8: If power-good drops during an access, that access stays blocked until chip-enable returns high, even if power-good comes back before then. The next access is then evaluated afresh.
- R9: The flags register (offset 0) reads bit 4 as the synchronized battery-low input and ignores writes to that bit. Its other seven bits are ordinary read/write storage.
- R10: After reset all registers read 0, `dq_oe` = 0, `dq_out` = 0, and all SRAM strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 19 | Host byte address |
| ce_n | input | 1 | Host chip-enable, active low |
| oe_n | input | 1 | Host output-enable, active low |
| we_n | input | 1 | Host write-enable, active low |
| wdata | input | 8 | Host write data |
| pwr_good | input | 1 | Asynchronous supply-good indication |
| batt_low | input | 1 | Asynchronous battery-low status |
| sram_ce_n | output | 1 | Chip-enable to external SRAM |
| sram_oe_n | output | 1 | Output-enable to external SRAM |
| sram_we_n | output | 1 | Write-enable to external SRAM |
| dq_out | output | 8 | Register read data |
| dq_oe | output | 1 | Drive enable for `dq_out` onto the data bus |

## Verification
The bench probes the window edge at 7FFEFh against 7FFF0h. A decoder off by one there would either hand a register cycle to the SRAM or take away the SRAM's last byte. It lowers write-enable under an active output-enable and expects the drive to stop and the new byte to land. A design that kept driving would collide with the host's data. It drops power-good in the middle of a register read and restores it before chip-enable is released. A design that re-evaluated power every cycle would resume driving there, while one that latched the block forever would fail the fresh read that follows. Writes of all ones to the flags register check that the battery bit stays tied to its input and the other bits take the written value.

// File: rtl/regwin_pkg.sv
// Package: shared defaults for the register window decoder.
// Assumes a byte-wide data path and a window at the top of the address space.
package regwin_pkg;
    localparam int ADDR_W      = 19;  // host address width (512K bytes)
    localparam int DATA_W      = 8;   // byte-wide data path
    localparam int WIN_BITS    = 4;   // window holds 2**WIN_BITS registers
    localparam int SYNC_STAGES = 2;   // depth of the input synchronizers
    localparam int FLAG_OFS    = 0;   // offset of the flags register
    localparam int BATT_BIT    = 4;   // read-only battery-low bit in flags

    // Active-high form of the host strobes after sampling.
    typedef struct packed {
        logic sel;  // chip enabled
        logic rd;   // output enabled
        logic wr;   // write enabled
    } host_req_t;
endpackage

// File: rtl/rwd_sync.sv
// Module: rwd_sync
// Multi-flop synchronizer for one asynchronous level input.
// Assumes STAGES >= 2; resets to 0 (treated as "not asserted").
module rwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rwd_pwr_gate.sv
// Module: rwd_pwr_gate
// Decides, per cycle, whether the current access may proceed.
// Power is judged at the first cycle of an access; a drop during the
// access blocks the remainder until chip-enable is released.
// Assumes pg_ok is already synchronous to clk.
module rwd_pwr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_ok,
    input  logic access,
    output logic allow
);
    logic prev_access;
    logic prev_allow;
    logic start;

    assign start = access & ~prev_access;

    // Combine the access start check with the running permission.
    always_comb begin
        if (!access)    allow = 1'b0;
        else if (start) allow = pg_ok;
        else            allow = prev_allow & pg_ok;
    end

    // Remember access and permission state from the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_access <= 1'b0;
            prev_allow  <= 1'b0;
        end else begin
            prev_access <= access;
            prev_allow  <= allow;
        end
    end
endmodule

// File: rtl/rwd_decode.sv
// Module: rwd_decode
// Splits a permitted host access between the register window and the
// external SRAM, and registers the SRAM strobes.
// Assumes the window occupies the top 2**WIN_BITS addresses.
module rwd_decode #(
    parameter int ADDR_W   = 19,
    parameter int WIN_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  regwin_pkg::host_req_t req,
    input  logic                allow,
    output logic [WIN_BITS-1:0] idx,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic                sram_ce_n,
    output logic                sram_oe_n,
    output logic                sram_we_n
);
    logic in_win;
    logic sram_sel;

    assign in_win   = &addr[ADDR_W-1:WIN_BITS];
    assign idx      = addr[WIN_BITS-1:0];
    assign sram_sel = allow & ~in_win;
    assign reg_wr   = allow & in_win & req.wr;
    assign reg_rd   = allow & in_win & req.rd & ~req.wr;

    // Register the SRAM strobes; the window masks chip- and output-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_we_n <= 1'b1;
        end else begin
            sram_ce_n <= ~sram_sel;
            sram_oe_n <= ~(sram_sel & req.rd);
            sram_we_n <= ~(allow & req.wr);
        end
    end

    // Sanity check on the ignored select bit: sel is folded into allow.
    logic unused_sel;
    assign unused_sel = req.sel;
endmodule

// File: rtl/rwd_regfile.sv
// Module: rwd_regfile
// Window register file with a registered read port and bus drive enable.
// The flags entry keeps one bit tied to the battery-low status.
// Assumes at most one of wr/rd is set in a cycle.
module rwd_regfile #(
    parameter int DATA_W   = 8,
    parameter int WIN_BITS = 4,
    parameter int FLAG_OFS = 0,
    parameter int BATT_BIT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [WIN_BITS-1:0] idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                batt_low,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe
);
    localparam int DEPTH = 1 << WIN_BITS;
    localparam logic [DATA_W-1:0] RO_MASK = DATA_W'(1) << BATT_BIT;

    logic [DATA_W-1:0] regs [DEPTH];
    logic [DATA_W-1:0] rd_word;

    // Store write data; the read-only flag bit is kept at zero in storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (wr) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (idx == WIN_BITS'(i))
                    regs[i] <= (i == FLAG_OFS) ? (wdata & ~RO_MASK) : wdata;
            end
        end
    end

    // Select the addressed word and overlay the live battery status.
    always_comb begin
        rd_word = regs[idx];
        if (idx == WIN_BITS'(FLAG_OFS))
            rd_word[BATT_BIT] = batt_low;
    end

    // Register the read data and the drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe  <= rd;
            dq_out <= rd ? rd_word : '0;
        end
    end
endmodule

// File: rtl/regwin_decoder.sv
// Module: regwin_decoder
// Top of the register window decoder: synchronizes power-good and
// battery-low, gates accesses on power, routes the top window to the
// register file and the rest of the space to the external SRAM.
// Assumes host strobes are synchronous to clk.
module regwin_decoder #(
    parameter int ADDR_W      = regwin_pkg::ADDR_W,
    parameter int DATA_W      = regwin_pkg::DATA_W,
    parameter int WIN_BITS    = regwin_pkg::WIN_BITS,
    parameter int SYNC_STAGES = regwin_pkg::SYNC_STAGES,
    parameter int FLAG_OFS    = regwin_pkg::FLAG_OFS,
    parameter int BATT_BIT    = regwin_pkg::BATT_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pwr_good,
    input  logic              batt_low,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    regwin_pkg::host_req_t req;
    logic                  pg_ok;
    logic                  batt_s;
    logic                  allow;
    logic [WIN_BITS-1:0]   idx;
    logic                  reg_wr;
    logic                  reg_rd;

    assign req.sel = ~ce_n;
    assign req.rd  = ~ce_n & ~oe_n;
    assign req.wr  = ~ce_n & ~we_n;

    rwd_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
        .clk(clk), .rst_n(rst_n), .d(pwr_good), .q(pg_ok)
    );

    rwd_sync #(.STAGES(SYNC_STAGES)) u_bl_sync (
        .clk(clk), .rst_n(rst_n), .d(batt_low), .q(batt_s)
    );

    rwd_pwr_gate u_gate (
        .clk(clk), .rst_n(rst_n), .pg_ok(pg_ok), .access(req.sel), .allow(allow)
    );

    rwd_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .req(req), .allow(allow),
        .idx(idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    rwd_regfile #(
        .DATA_W(DATA_W), .WIN_BITS(WIN_BITS),
        .FLAG_OFS(FLAG_OFS), .BATT_BIT(BATT_BIT)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .idx(idx),
        .wdata(wdata), .batt_low(batt_s), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/regwin_decoder_chk.sv
// Module: regwin_decoder_chk
// Property checker for regwin_decoder, attached by bind below.
module regwin_decoder_chk #(
    parameter int ADDR_W   = 19,
    parameter int WIN_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              we_n,
    input logic              pg_ok,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              dq_oe
);
    // R2: window access keeps SRAM chip- and output-enable inactive
    a_r2_window_masks_sram: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && (&addr[ADDR_W-1:WIN_BITS])) |=> (sram_ce_n && sram_oe_n));

    // R5: write-enable low removes the data drive next cycle
    a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dq_oe);

    // R5: register drive and SRAM output-enable never coincide
    a_r5_exclusive_drivers: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !sram_oe_n));

    // R6: deselect leaves everything inactive
    a_r6_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (sram_ce_n && !dq_oe));

    // R7: bad power blocks SRAM select and register drive
    a_r7_power_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_ok |=> (sram_ce_n && !dq_oe));
endmodule

bind regwin_decoder regwin_decoder_chk #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .pg_ok(pg_ok), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .dq_oe(dq_oe)
);

// File: tb/regwin_decoder_bench.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor
// pops and compares them one cycle after each stimulus.
module regwin_decoder_bench;
    localparam logic [18:0] WIN = 19'h7FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0]  wdata = '0;
    logic        pwr_good = 1'b0, batt_low = 1'b0;
    logic        sram_ce_n, sram_oe_n, sram_we_n, dq_oe;
    logic [7:0]  dq_out;

    regwin_decoder u_regwin_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .wdata(wdata), .pwr_good(pwr_good), .batt_low(batt_low),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;  // 250 MHz

    typedef struct {
        int         due;
        logic [3:0] strobes;  // sce, soe, swe, doe
        logic [7:0] dout;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0, n_bad = 0;
    bit   done = 0;
    bit   model_allow = 0;
    bit   model_batt = 0;
    logic [7:0] model_regs [16];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare the entry due in this cycle.
    always @(negedge clk) begin
        if (q.size() != 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if ({sram_ce_n, sram_oe_n, sram_we_n, dq_oe} !== e.strobes || dq_out !== e.dout) begin
                n_bad++;
                $display("FAIL %s: got ce/oe/we/drv=%b dq=%h, expected %b dq=%h",
                         e.req, {sram_ce_n, sram_oe_n, sram_we_n, dq_oe}, dq_out,
                         e.strobes, e.dout);
            end
        end
    end

    // Direct check used for the reset state.
    task automatic check_now(input logic [3:0] s, input logic [7:0] d, input string r);
        n_cmp++;
        if ({sram_ce_n, sram_oe_n, sram_we_n, dq_oe} !== s || dq_out !== d) begin
            n_bad++;
            $display("FAIL %s: got %b dq=%h, expected %b dq=%h",
                     r, {sram_ce_n, sram_oe_n, sram_we_n, dq_oe}, dq_out, s, d);
        end
    endtask

    // Driver: apply one cycle of host inputs and predict the result.
    task automatic step(input logic c, input logic o, input logic w,
                        input logic [18:0] a, input logic [7:0] wd,
                        input bit chk, input string r);
        bit en, win, drv;
        logic [7:0] rv;
        exp_t e;
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; addr = a; wdata = wd;
        win = (a[18:4] == 15'h7FFF);
        en  = !c && model_allow;
        drv = en && win && !o && w;
        rv  = model_regs[a[3:0]];
        if (a[3:0] == 4'd0) rv[4] = model_batt;
        e.due     = cyc + 1;
        e.strobes = {!(en && !win), !(en && !win && !o), !(en && !w), drv};
        e.dout    = drv ? rv : 8'h00;
        e.req     = r;
        if (chk) q.push_back(e);
        if (en && win && !w)
            model_regs[a[3:0]] = (a[3:0] == 4'd0) ? (wd & 8'hEF) : wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 1, 19'h0, 8'h00, 1, "R6 idle");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        check_now(4'b1110, 8'h00, "R10 reset outputs");
        @(negedge clk);
        rst_n = 1'b1;

        // R7: power not yet good: SRAM access and register write are blocked
        step(0, 0, 1, 19'h00123, 8'h00, 1, "R7 sram read blocked");
        step(0, 1, 0, WIN + 19'd3, 8'h77, 1, "R7 reg write ignored");
        idle(1);

        pwr_good = 1'b1;
        idle(4);
        model_allow = 1;

        // R10: registers start at zero
        step(0, 0, 1, WIN + 19'd3, 8'h00, 1, "R10/R7 reg3 reads zero");
        // R3: SRAM read and write pass through
        step(0, 0, 1, 19'h00123, 8'h00, 1, "R3 sram read");
        step(0, 1, 0, 19'h00456, 8'h5A, 1, "R3 sram write");
        step(0, 1, 1, 19'h00456, 8'h00, 1, "R3 sram selected no oe");
        // R1: last SRAM byte below the window
        step(0, 0, 1, 19'h7FFEF, 8'h00, 1, "R1 boundary 7FFEF is sram");
        idle(1);
        // R4/R2: register writes and reads
        step(0, 1, 0, WIN + 19'd5, 8'hA5, 1, "R4/R2 write reg5");
        step(0, 1, 0, WIN + 19'd15, 8'h3C, 1, "R4/R1 write reg15");
        step(0, 0, 1, WIN + 19'd5, 8'h00, 1, "R4 read reg5");
        step(0, 0, 1, WIN + 19'd15, 8'h00, 1, "R4/R1 read reg15");
        step(0, 0, 1, WIN, 8'h00, 1, "R1 7FFF0 is window");
        // R5: write-enable falls under an active output-enable
        step(0, 0, 0, WIN + 19'd5, 8'h11, 1, "R5 drive off during write");
        step(0, 0, 1, WIN + 19'd5, 8'h00, 1, "R5 read after write");
        idle(1);
        // R6: deselected with other strobes active
        step(1, 0, 0, WIN + 19'd5, 8'hFF, 1, "R6 deselect ignores strobes");
        step(0, 0, 1, WIN + 19'd5, 8'h00, 1, "R6 reg5 unchanged");
        // R9: flags register bit 4
        step(0, 1, 0, WIN, 8'hFF, 1, "R9 flags write ones");
        step(0, 0, 1, WIN, 8'h00, 1, "R9 flags reads EF");
        idle(1);
        batt_low = 1'b1;
        idle(4);
        model_batt = 1;
        step(0, 0, 1, WIN, 8'h00, 1, "R9 flags with batt low");
        step(0, 1, 0, WIN, 8'h00, 1, "R9 flags clear writable");
        step(0, 0, 1, WIN, 8'h00, 1, "R9 batt bit survives write");
        idle(1);

        // R8: power drops mid-access and returns before deselect
        step(0, 0, 1, WIN + 19'd15, 8'h00, 1, "R8 read before drop");
        pwr_good = 1'b0;
        for (int i = 0; i < 4; i++) step(0, 0, 1, WIN + 19'd15, 8'h00, 0, "");
        model_allow = 0;
        step(0, 0, 1, WIN + 19'd15, 8'h00, 1, "R8 blocked after drop");
        pwr_good = 1'b1;
        for (int i = 0; i < 4; i++) step(0, 0, 1, WIN + 19'd15, 8'h00, 0, "");
        step(0, 0, 1, WIN + 19'd15, 8'h00, 1, "R8 still blocked in access");
        step(0, 1, 0, WIN + 19'd15, 8'h99, 1, "R8 write in blocked access");
        model_allow = 1;
        idle(1);
        step(0, 0, 1, WIN + 19'd15, 8'h00, 1, "R8 fresh access allowed");
        step(0, 0, 1, 19'h00010, 8'h00, 1, "R8 sram after recovery");
        idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule